// File: doc/BRIEF.md
# Pipelined Histogram Accumulator with Hazard Forwarding

This block builds a histogram in a synchronous RAM. Each accepted input names a bin. The bin number addresses a RAM read, and the returned count goes up by one. The new count is written back to the same bin two cycles after the read. Register stages carry the bin, the valid flag and the epoch alongside the RAM latency, so the read-modify-write loop needs no combinational path through the RAM.

A younger hit on the same bin can arrive before the older update lands in the RAM, or in the same cycle that it lands. In that case the pending count is forwarded from the pipeline, so every arrival pattern, back-to-back hits included, is counted exactly. The RAM cannot be reset, so a clear moves a small epoch counter forward instead of zeroing the array. Each RAM word carries the epoch of its last write, and a word from an older epoch reads as zero. Only when the epoch counter would wrap does the block sweep zeros through the whole array, and it does the same once after reset. A separate host port reads any bin at any time.

Top module: `bin_tally`

## Requirements
- R1: Every accepted hit (`hit_valid` high while `ready` is high and `clear_req` is low) raises the count of bin `hit_bin` by exactly one. A host read issued three or more cycles after the hit sees the new count.
- R2: Hits on the same bin in consecutive cycles are all counted. A run of N such hits adds N.
- R3: Hits on the same bin two cycles apart, with any other bin or no hit between them, are both counted.
- R4: A count stops at 2^CNT_W-1 (255 with the defaults) and never wraps to a smaller value.
- R5: A clear accepted while `ready` is high and the epoch is below its top value makes every bin read zero. `ready` stays high, and later hits count up from zero.
- R6: After reset `ready` is low for exactly 2^BIN_W cycles (64 with the defaults). Once it rises, every bin reads zero.
- R7: Each reset or wrap sweep leaves the epoch at 0, and 2^EPOCH_W-1 clears (3 with the defaults) raise it to its top value. A clear taken at the top value holds `ready` low for exactly 2^BIN_W cycles. Afterwards every bin reads zero.
- R8: A hit presented while `ready` is low, or in the same cycle as `clear_req`, is dropped and leaves every count unchanged.
- R9: `rd_data` presents the count of bin `rd_addr` in the cycle after `rd_en` is high, and holds that value until the next `rd_en`.
- R10: A hit accepted one cycle before a clear, whose write-back is still in flight, does not appear in the count after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the zeroing sweep |
| hit_valid | input | 1 | A bin hit is presented this cycle |
| hit_bin | input | BIN_W | Bin number of the hit |
| clear_req | input | 1 | Request to clear every bin |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | BIN_W | Bin the host reads |
| rd_data | output | CNT_W | Count of the bin last read |
| ready | output | 1 | High when hits and clears are accepted; low during a sweep |

## Verification
Scattered hits on distinct bins show the basic increment with no hazard in play. Unbroken runs on one bin test forwarding from the stage whose write is pending. An A-B-A-B interleave and an A-gap-A pattern test forwarding from the stage written in the same cycle as the read, and a random stream of bins with short repeated runs mixes all the hazard distances. Several clear cases tell an in-flight stale update apart from a fresh count and tell the quick epoch clear apart from the sweep at the wrap. Hits in clear cycles or during a sweep confirm the dropping rule.

// File: rtl/bt_pkg.sv
package bt_pkg;

   // Source of the single RAM write port
   typedef enum logic {
      WSRC_PIPE  = 1'b0,
      WSRC_SWEEP = 1'b1
   } wsrc_e;

   // Stages between the RAM read request and the registered write-back
   localparam int unsigned BT_RD_LAT = 1;
   // Forwarding depth: the pending write plus the write landing with a read
   localparam int unsigned BT_FWD_N  = BT_RD_LAT + 1;

endpackage

// File: rtl/bt_ram.sv
module bt_ram #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic          ren_a,
   input  logic [AW-1:0] ra_a,
   output logic [DW-1:0] qa,
   input  logic          ren_b,
   input  logic [AW-1:0] ra_b,
   output logic [DW-1:0] qb
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Array has no reset, like a real block RAM
   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   // Read registers return the old word on a same-edge write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qa <= '0;
         qb <= '0;
      end else begin
         if (ren_a) qa <= mem[ra_a];
         if (ren_b) qb <= mem[ra_b];
      end
   end
endmodule

// File: rtl/bt_clear_ctl.sv
module bt_clear_ctl #(
   parameter int unsigned BIN_W   = 6,
   parameter int unsigned EPOCH_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_req,
   output logic               ready,
   output logic [EPOCH_W-1:0] epoch,
   output logic               sweep_we,
   output logic [BIN_W-1:0]   sweep_addr
);
   logic sweep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sweep      <= 1'b1;
         sweep_addr <= '0;
         epoch      <= '0;
      end else if (sweep) begin
         sweep_addr <= sweep_addr + 1'b1;
         if (&sweep_addr) sweep <= 1'b0;
      end else if (clear_req) begin
         if (&epoch) begin
            sweep      <= 1'b1;
            sweep_addr <= '0;
            epoch      <= '0;
         end else begin
            epoch <= epoch + 1'b1;
         end
      end
   end

   assign ready    = ~sweep;
   assign sweep_we = sweep;

   // R7
   wrap_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && !sweep && (&epoch)) |=> (sweep && sweep_addr == '0 && epoch == '0))
      else $error("wrap clear did not start a sweep");

   // R5
   epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && !sweep && !(&epoch)) |=> (!sweep && epoch == $past(epoch) + 1'b1))
      else $error("clear did not advance the epoch");

   // R6
   sweep_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sweep && !(&sweep_addr)) |=> (sweep && sweep_addr == $past(sweep_addr) + 1'b1))
      else $error("sweep skipped or ended early");
endmodule

// File: rtl/bt_update.sv
module bt_update
   import bt_pkg::*;
#(
   parameter int unsigned BIN_W    = 6,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned EPOCH_W  = 2,
   parameter bit          SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc,
   input  logic [BIN_W-1:0]   bin_in,
   input  logic [EPOCH_W-1:0] epoch,
   input  logic [CNT_W-1:0]   ram_cnt,
   input  logic [EPOCH_W-1:0] ram_tag,
   output logic               wr_v,
   output logic [BIN_W-1:0]   wr_bin,
   output logic [EPOCH_W-1:0] wr_ep,
   output logic [CNT_W-1:0]   wr_cnt
);
   localparam int unsigned FWD = BT_FWD_N;
   localparam logic [CNT_W-1:0] CMAX = '1;

   // Stage aligned with the RAM read data
   logic               v1;
   logic [BIN_W-1:0]   bin1;
   logic [EPOCH_W-1:0] ep1;

   // History: [0] = write pending, [1] = write landing this cycle
   logic               hv   [FWD];
   logic [BIN_W-1:0]   hbin [FWD];
   logic [EPOCH_W-1:0] hep  [FWD];
   logic [CNT_W-1:0]   hcnt [FWD];

   logic [FWD-1:0]     fmatch;
   logic [CNT_W-1:0]   base;
   logic [CNT_W-1:0]   nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1   <= 1'b0;
         bin1 <= '0;
         ep1  <= '0;
      end else begin
         v1   <= acc;
         bin1 <= bin_in;
         ep1  <= epoch;
      end
   end

   genvar k;
   generate
      for (k = 0; k < FWD; k++) begin : g_match
         assign fmatch[k] = hv[k] && (hbin[k] == bin1) && (hep[k] == ep1);
      end
   endgenerate

   // Newest matching stage wins; otherwise the RAM word, zero if stale
   always_comb begin
      base = (ram_tag == ep1) ? ram_cnt : '0;
      for (int i = FWD - 1; i >= 0; i--) begin
         if (fmatch[i]) base = hcnt[i];
      end
   end

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (base == CMAX) ? base : CNT_W'(base + 1'b1);
      end else begin : g_wrap
         assign nxt = CNT_W'(base + 1'b1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < FWD; i++) begin
            hv[i]   <= 1'b0;
            hbin[i] <= '0;
            hep[i]  <= '0;
            hcnt[i] <= '0;
         end
      end else begin
         hv[0]   <= v1;
         hbin[0] <= bin1;
         hep[0]  <= ep1;
         hcnt[0] <= nxt;
         for (int i = 1; i < FWD; i++) begin
            hv[i]   <= hv[i-1];
            hbin[i] <= hbin[i-1];
            hep[i]  <= hep[i-1];
            hcnt[i] <= hcnt[i-1];
         end
      end
   end

   assign wr_v   = hv[0];
   assign wr_bin = hbin[0];
   assign wr_ep  = hep[0];
   assign wr_cnt = hcnt[0];

   generate
      if (SATURATE) begin : g_sat_chk
         // R4
         no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hv[0] |-> (hcnt[0] != '0))
            else $error("count wrapped to zero");
      end
   endgenerate

   // R2
   fwd_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v1 && hv[0] && bin1 == hbin[0] && ep1 == hep[0] && hcnt[0] != CMAX)
      |=> (hcnt[0] == CNT_W'($past(hcnt[0]) + 1'b1)))
      else $error("back-to-back hit lost");

   // R3
   fwd_landing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v1 && !(hv[0] && bin1 == hbin[0] && ep1 == hep[0])
          && hv[1] && bin1 == hbin[1] && ep1 == hep[1] && hcnt[1] != CMAX)
      |=> (hcnt[0] == CNT_W'($past(hcnt[1]) + 1'b1)))
      else $error("hit two cycles apart lost");
endmodule

// File: rtl/bin_tally.sv
module bin_tally
   import bt_pkg::*;
#(
   parameter int unsigned BIN_W    = 6,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned EPOCH_W  = 2,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_valid,
   input  logic [BIN_W-1:0] hit_bin,
   input  logic             clear_req,
   input  logic             rd_en,
   input  logic [BIN_W-1:0] rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             ready
);
   localparam int unsigned WORD_W = CNT_W + EPOCH_W;

   generate
      if (BIN_W < 2 || BIN_W > 12) begin : g_bad_bin
         $error("BIN_W must lie in 2..12");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (EPOCH_W < 1 || EPOCH_W > 8) begin : g_bad_ep
         $error("EPOCH_W must lie in 1..8");
      end
   endgenerate

   logic               acc;
   logic [EPOCH_W-1:0] epoch;
   logic               sweep_we;
   logic [BIN_W-1:0]   sweep_addr;
   logic               up_v;
   logic [BIN_W-1:0]   up_bin;
   logic [EPOCH_W-1:0] up_ep;
   logic [CNT_W-1:0]   up_cnt;
   logic               ram_we;
   logic [BIN_W-1:0]   ram_wa;
   logic [WORD_W-1:0]  ram_wd;
   logic [WORD_W-1:0]  qa, qb;
   logic [EPOCH_W-1:0] rd_ep;
   wsrc_e              wsrc;

   assign acc = hit_valid & ready & ~clear_req;

   bt_clear_ctl #(.BIN_W(BIN_W), .EPOCH_W(EPOCH_W)) u_clear (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_req  (clear_req),
      .ready      (ready),
      .epoch      (epoch),
      .sweep_we   (sweep_we),
      .sweep_addr (sweep_addr)
   );

   bt_update #(.BIN_W(BIN_W), .CNT_W(CNT_W), .EPOCH_W(EPOCH_W),
               .SATURATE(SATURATE)) u_update (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .bin_in  (hit_bin),
      .epoch   (epoch),
      .ram_cnt (qa[CNT_W-1:0]),
      .ram_tag (qa[WORD_W-1:CNT_W]),
      .wr_v    (up_v),
      .wr_bin  (up_bin),
      .wr_ep   (up_ep),
      .wr_cnt  (up_cnt)
   );

   // Sweep owns the write port; pipeline writes then belong to a dead epoch
   assign wsrc   = sweep_we ? WSRC_SWEEP : WSRC_PIPE;
   assign ram_we = (wsrc == WSRC_SWEEP) | up_v;
   assign ram_wa = (wsrc == WSRC_SWEEP) ? sweep_addr : up_bin;
   assign ram_wd = (wsrc == WSRC_SWEEP) ? '0 : {up_ep, up_cnt};

   bt_ram #(.AW(BIN_W), .DW(WORD_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we),
      .wa    (ram_wa),
      .wd    (ram_wd),
      .ren_a (acc),
      .ra_a  (hit_bin),
      .qa    (qa),
      .ren_b (rd_en),
      .ra_b  (rd_addr),
      .qb    (qb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_ep <= '0;
      else if (rd_en) rd_ep <= epoch;
   end

   assign rd_data = (qb[WORD_W-1:CNT_W] == rd_ep) ? qb[CNT_W-1:0] : '0;

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data))
      else $error("host data changed without a read");

   // R8
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && (!ready || clear_req)) |=> !$past(acc))
      else $error("hit accepted while blocked");
endmodule

// File: tb/bin_tally_bench.sv
module bin_tally_bench;
   localparam int BIN_W = 6;
   localparam int CNT_W = 8;
   localparam int NB    = 1 << BIN_W;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hit_valid = 1'b0;
   logic [BIN_W-1:0] hit_bin = '0;
   logic             clear_req = 1'b0;
   logic             rd_en = 1'b0;
   logic [BIN_W-1:0] rd_addr = '0;
   logic [CNT_W-1:0] rd_data;
   logic             ready;

   int model [NB];
   int n_chk = 0;
   int n_bad = 0;
   int bench_ep = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bin_tally #(.BIN_W(BIN_W), .CNT_W(CNT_W), .EPOCH_W(2)) u_bin_tally (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_bin(hit_bin),
      .clear_req(clear_req), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .ready(ready)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic model_zero();
      for (int i = 0; i < NB; i++) model[i] = 0;
   endtask

   // One hit cycle; the model counts it only when it is accepted
   task automatic do_hit(input int b, input bit counts);
      hit_valid = 1'b1;
      hit_bin   = BIN_W'(b);
      @(negedge clk);
      hit_valid = 1'b0;
      if (counts && model[b] < CMAX) model[b]++;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_bin(input int b, output int v);
      rd_en   = 1'b1;
      rd_addr = BIN_W'(b);
      @(negedge clk);
      rd_en = 1'b0;
      v = int'(rd_data);
   endtask

   task automatic check_all(input string req);
      int v;
      idle(4);
      for (int i = 0; i < NB; i++) begin
         read_bin(i, v);
         check(req, v, model[i]);
      end
   endtask

   // Counts cycles with ready low, starting at the current negedge
   task automatic low_cycles(output int n);
      n = 0;
      while (!ready && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      int n;
      check("R6 ready low in reset", int'(ready), 0);
      rst_n = 1'b1;
      low_cycles(n);
      check("R6 sweep length after reset", n, NB);
      model_zero();
      check_all("R6 zero after reset");
   endtask

   task automatic t_scatter();
      int v;
      do_hit(3, 1); idle(2); do_hit(17, 1); do_hit(40, 1); idle(1); do_hit(63, 1);
      do_hit(0, 1);
      idle(3);
      read_bin(17, v);
      check("R1 read three cycles after hit", v, 1);
      read_bin(0, v);
      check("R9 read of bin 0", v, 1);
      idle(2);
      check("R9 data held without read", int'(rd_data), 1);
      check_all("R1 scattered hits");
   endtask

   task automatic t_burst();
      for (int i = 0; i < 10; i++) do_hit(9, 1);
      do_hit(10, 1);
      for (int i = 0; i < 3; i++) do_hit(10, 1);
      check_all("R2 consecutive same-bin run");
   endtask

   task automatic t_interleave();
      for (int i = 0; i < 8; i++) do_hit((i % 2 == 0) ? 20 : 21, 1);
      for (int i = 0; i < 4; i++) begin
         do_hit(30, 1);
         idle(1);
      end
      do_hit(31, 1); do_hit(32, 1); do_hit(31, 1); do_hit(32, 1);
      check_all("R3 hits two cycles apart");
   endtask

   task automatic t_random();
      int b = 0;
      int run = 0;
      for (int i = 0; i < 400; i++) begin
         if (run == 0) begin
            b   = $urandom_range(NB - 1, 0);
            run = $urandom_range(4, 1);
         end
         run--;
         if ($urandom_range(5, 0) == 0) idle(1);
         do_hit(b, 1);
      end
      check_all("R1 random bins with runs");
   endtask

   task automatic t_saturate();
      int v;
      for (int i = 0; i < 300; i++) do_hit(50, 1);
      idle(4);
      read_bin(50, v);
      check("R4 saturation value", v, CMAX);
   endtask

   task automatic do_clear();
      clear_req = 1'b1;
      @(negedge clk);
      clear_req = 1'b0;
   endtask

   task automatic t_clear();
      int v;
      // in-flight hit followed by a clear
      do_hit(12, 0);
      do_clear();
      bench_ep++;
      model_zero();
      check("R5 ready stays high on clear", int'(ready), 1);
      idle(4);
      read_bin(12, v);
      check("R10 in-flight hit gone after clear", v, 0);
      check_all("R5 zero after clear");
      do_hit(12, 1); do_hit(12, 1); do_hit(5, 1);
      // hit in the same cycle as a clear is dropped
      clear_req = 1'b1;
      hit_valid = 1'b1;
      hit_bin   = BIN_W'(7);
      @(negedge clk);
      clear_req = 1'b0;
      hit_valid = 1'b0;
      bench_ep++;
      model_zero();
      idle(4);
      read_bin(7, v);
      check("R8 hit with clear dropped", v, 0);
      do_hit(12, 1);
      check_all("R5 counting restarts after clear");
   endtask

   task automatic t_wrap();
      int n;
      do_hit(22, 1);
      do_clear();
      bench_ep++;
      model_zero();
      check("R7 epoch count before wrap", bench_ep, 3);
      check("R5 ready high on third clear", int'(ready), 1);
      do_hit(22, 1); do_hit(23, 1);
      idle(3);
      do_clear();
      bench_ep = 0;
      model_zero();
      check("R7 ready low after wrap clear", int'(ready), 0);
      // hits during the sweep are dropped
      do_hit(25, 0); do_hit(25, 0);
      low_cycles(n);
      check("R7 sweep length after wrap", n + 2, NB);
      check_all("R7 zero after wrap sweep");
      do_hit(25, 1); do_hit(25, 1);
      check_all("R8 only post-sweep hits counted");
   endtask

   initial begin
      model_zero();
      idle(3);
      t_reset();
      t_scatter();
      t_burst();
      t_interleave();
      t_random();
      t_saturate();
      t_clear();
      t_wrap();
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule